// File: doc/BRIEF.md
# Register Access Endpoint with Programmable Wait States

This block is the slave end of a synchronous register-access port. A requester pulses a one-cycle enable together with a read/write select, an address and, for writes, a data word. The endpoint answers every request, read or write, with a ready pulse one clock cycle long. The pulse comes after a number of wait states. On a read, the word from the addressed register is on the read-data bus in that ready cycle. The endpoint keeps a small bank of registers behind the port.

The number of wait states is `WAIT_CYCLES`. When `ADDR_WAIT` is 1, the two low address bits are added to it. The total is capped at 15. The address is captured in the enable cycle, so a requester can change the buses once its request has been taken. An enable that arrives while a request is still open is refused and reported on an error pulse. An enable in the ready cycle of the previous request is taken as a new request.

Top module: `regport_endpoint`

## Requirements
- R1: After reset, `rdy`, `proto_err` and `rdata` are low and every register reads back as zero.
- R2: A request with `en`=1 and `wr`=1 stores `wdata` into the register selected by `addr`. A later read of that address returns the stored word.
- R3: Each accepted request produces one `rdy` cycle, and only one. Let the enable cycle be c and let W = min(15, `WAIT_CYCLES` + (`ADDR_WAIT` ? `addr[1:0]` : 0)). Then `rdy` is high in cycle c+1+W and low in cycles c+1 to c+W.
- R4: When W is 0, `rdy` is high in the cycle right after the enable cycle.
- R5: In the `rdy` cycle of a read, `rdata` carries the contents of the register addressed in the enable cycle.
- R6: `rdata` keeps its last value in every cycle that is not a read's `rdy` cycle. This includes the `rdy` cycle of a write.
- R7: `addr` and `wdata` are sampled only in the enable cycle. Changing them during the wait states has no effect on the register written or the register read.
- R8: An `en` that arrives while a request is open is dropped. It writes nothing and produces no extra `rdy`, and `proto_err` is high in the cycle after it.
- R9: An `en` in the `rdy` cycle of the previous request is accepted as a new request and raises no `proto_err`.
- R10: `rdy` is never high unless a request was accepted earlier and has not yet been answered.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Port clock, rising edge active |
| rst_n | input | 1 | Active-low reset |
| en | input | 1 | One-cycle request strobe |
| wr | input | 1 | 1 = write, 0 = read, sampled with `en` |
| addr | input | AW | Register index, sampled with `en` |
| wdata | input | DW | Write word, sampled with `en` |
| rdata | output | DW | Read word, valid in a read's `rdy` cycle, held otherwise |
| rdy | output | 1 | One-cycle completion pulse |
| proto_err | output | 1 | Pulse for a refused overlapping `en` |

## Verification
The bench builds the endpoint with eight registers of 16 bits, `WAIT_CYCLES` = 0 and `ADDR_WAIT` = 1. With these settings a single instance produces every wait count from zero to three, and the count is chosen only by the address. Address 0 exercises the zero-wait case and back-to-back requests in the ready cycle. Address 3 leaves enough open cycles to scramble the buses and to inject an overlapping strobe before the pulse arrives.

// File: rtl/regport_pkg.sv
package regport_pkg;

    localparam int WAIT_W   = 4;
    localparam int WAIT_MAX = 15;

    typedef struct packed {
        logic              busy;
        logic [WAIT_W-1:0] cnt;
        logic              wr;
        logic              rdy;
        logic              rd_rdy;
        logic              err;
    } ctrl_state_t;

endpackage

// File: rtl/regport_wait_calc.sv
module regport_wait_calc
    import regport_pkg::*;
#(
    parameter int AW          = 3,
    parameter int WAIT_CYCLES = 2,
    parameter bit ADDR_WAIT   = 1'b0
) (
    input  logic [AW-1:0]     addr,
    output logic [WAIT_W-1:0] wait_n
);

    localparam int SUM_W = WAIT_W + 1;
    localparam logic [SUM_W-1:0] BASE = SUM_W'(WAIT_CYCLES);

    logic [SUM_W-1:0] sum;

    generate
        if (ADDR_WAIT && AW >= 2) begin : g_addr_wait
            always_comb sum = BASE + {{(SUM_W-2){1'b0}}, addr[1:0]};
        end else begin : g_fixed_wait
            logic unused_addr;
            always_comb unused_addr = ^addr;
            always_comb sum = BASE;
        end
    endgenerate

    always_comb begin
        if (sum > SUM_W'(WAIT_MAX))
            wait_n = WAIT_W'(WAIT_MAX);
        else
            wait_n = sum[WAIT_W-1:0];
    end

endmodule

// File: rtl/regport_ctrl.sv
module regport_ctrl
    import regport_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en,
    input  logic              wr,
    input  logic [WAIT_W-1:0] wait_n,
    output logic              accept,
    output logic              busy,
    output logic              rdy,
    output logic              rd_rdy,
    output logic              proto_err
);

    ctrl_state_t st_d, st_q;

    always_comb begin
        st_d        = st_q;
        st_d.rdy    = 1'b0;
        st_d.rd_rdy = 1'b0;
        st_d.err    = 1'b0;
        accept      = 1'b0;
        if (st_q.busy) begin
            if (en) st_d.err = 1'b1;
            if (st_q.cnt == '0) begin
                st_d.busy   = 1'b0;
                st_d.rdy    = 1'b1;
                st_d.rd_rdy = ~st_q.wr;
            end else begin
                st_d.cnt = st_q.cnt - 1'b1;
            end
        end else if (en) begin
            accept  = 1'b1;
            st_d.wr = wr;
            if (wait_n == '0) begin
                st_d.rdy    = 1'b1;
                st_d.rd_rdy = ~wr;
            end else begin
                st_d.busy = 1'b1;
                st_d.cnt  = wait_n - 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign busy      = st_q.busy;
    assign rdy       = st_q.rdy;
    assign rd_rdy    = st_q.rd_rdy;
    assign proto_err = st_q.err;

endmodule

// File: rtl/regport_regfile.sv
module regport_regfile #(
    parameter int AW = 3,
    parameter int DW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [DW-1:0] wdata,
    input  logic [AW-1:0] raddr,
    output logic [DW-1:0] rdata
);

    localparam int DEPTH = 1 << AW;

    logic [DW-1:0] regs_q [DEPTH];

    generate
        for (genvar i = 0; i < DEPTH; i++) begin : g_reg
            logic [DW-1:0] reg_d;
            always_comb reg_d = (we && waddr == AW'(i)) ? wdata : regs_q[i];
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) regs_q[i] <= '0;
                else        regs_q[i] <= reg_d;
            end
        end
    endgenerate

    assign rdata = regs_q[raddr];

endmodule

// File: rtl/regport_endpoint.sv
module regport_endpoint
    import regport_pkg::*;
#(
    parameter int AW          = 3,
    parameter int DW          = 16,
    parameter int WAIT_CYCLES = 2,
    parameter bit ADDR_WAIT   = 1'b0
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          en,
    input  logic          wr,
    input  logic [AW-1:0] addr,
    input  logic [DW-1:0] wdata,
    output logic [DW-1:0] rdata,
    output logic          rdy,
    output logic          proto_err
);

    logic [WAIT_W-1:0] wait_n;
    logic              accept;
    logic              busy;
    logic              rd_rdy;
    logic [DW-1:0]     rf_rdata;
    logic [AW-1:0]     addr_d, addr_q;
    logic [DW-1:0]     hold_d, hold_q;

    regport_wait_calc #(
        .AW(AW), .WAIT_CYCLES(WAIT_CYCLES), .ADDR_WAIT(ADDR_WAIT)
    ) u_wait (
        .addr(addr), .wait_n(wait_n)
    );

    regport_ctrl u_ctrl (
        .clk(clk), .rst_n(rst_n), .en(en), .wr(wr), .wait_n(wait_n),
        .accept(accept), .busy(busy), .rdy(rdy), .rd_rdy(rd_rdy),
        .proto_err(proto_err)
    );

    regport_regfile #(.AW(AW), .DW(DW)) u_rf (
        .clk(clk), .rst_n(rst_n), .we(accept & wr), .waddr(addr),
        .wdata(wdata), .raddr(addr_q), .rdata(rf_rdata)
    );

    always_comb begin
        addr_d = accept ? addr : addr_q;
        hold_d = rd_rdy ? rf_rdata : hold_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            addr_q <= '0;
            hold_q <= '0;
        end else begin
            addr_q <= addr_d;
            hold_q <= hold_d;
        end
    end

    assign rdata = rd_rdy ? rf_rdata : hold_q;

endmodule

// File: rtl/regport_endpoint_chk.sv
module regport_endpoint_chk #(
    parameter int DW = 16
) (
    input logic          clk,
    input logic          rst_n,
    input logic          en,
    input logic          rdy,
    input logic          proto_err,
    input logic [DW-1:0] rdata,
    input logic          busy
);

    logic [5:0] open_run_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                open_run_q <= '0;
        else if (!busy)            open_run_q <= '0;
        else if (open_run_q != '1) open_run_q <= open_run_q + 1'b1;
    end

    assert_wait_limit_R3: assert property (@(posedge clk) disable iff (!rst_n)
        open_run_q <= 6'd15);

    assert_err_cause_R8: assert property (@(posedge clk) disable iff (!rst_n)
        proto_err |-> $past(en) && $past(busy));

    assert_rdata_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (!rdy && !$past(rdy)) |-> $stable(rdata));

    assert_no_spurious_rdy_R10: assert property (@(posedge clk) disable iff (!rst_n)
        rdy |-> $past(busy) || $past(en));

    assert_reset_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> !rdy && !proto_err);

endmodule

bind regport_endpoint regport_endpoint_chk #(.DW(DW)) u_chk (
    .clk(clk), .rst_n(rst_n), .en(en), .rdy(rdy), .proto_err(proto_err),
    .rdata(rdata), .busy(busy)
);

// File: tb/regport_endpoint_tb.sv
module regport_endpoint_tb;

    localparam int CLK_PERIOD = 10;
    localparam int AW = 3;
    localparam int DW = 16;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          en = 1'b0;
    logic          wr = 1'b0;
    logic [AW-1:0] addr = '0;
    logic [DW-1:0] wdata = '0;
    logic [DW-1:0] rdata;
    logic          rdy;
    logic          proto_err;

    int checks = 0;
    int errors = 0;
    logic [DW-1:0] model [8];
    logic [DW-1:0] last_rd = '0;

    always #(CLK_PERIOD/2) clk = ~clk;

    regport_endpoint #(
        .AW(AW), .DW(DW), .WAIT_CYCLES(0), .ADDR_WAIT(1'b1)
    ) u_dut (
        .clk(clk), .rst_n(rst_n), .en(en), .wr(wr), .addr(addr),
        .wdata(wdata), .rdata(rdata), .rdy(rdy), .proto_err(proto_err)
    );

    function automatic int exp_wait(input logic [AW-1:0] a);
        int w = int'(a[1:0]);
        return (w > 15) ? 15 : w;
    endfunction

    task automatic check(input bit ok, input string tag, input logic [31:0] act,
                         input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Issue one request and follow it to its ready cycle; scrambles buses (R7).
    task automatic access(input logic [AW-1:0] a, input logic w,
                          input logic [DW-1:0] d, input string tag);
        int n = exp_wait(a);
        @(negedge clk);
        en = 1'b1; wr = w; addr = a; wdata = d;
        @(posedge clk);
        @(negedge clk);
        en = 1'b0; addr = ~a; wdata = ~d;
        for (int i = 0; i < n; i++) begin
            check(rdy == 1'b0, {tag, " R3 early rdy"}, 32'(rdy), 0);
            @(negedge clk);
        end
        check(rdy == 1'b1, {tag, " R3 rdy timing"}, 32'(rdy), 1);
        if (w) begin
            model[a] = d;
            check(rdata == last_rd, {tag, " R6 hold on write"}, 32'(rdata), 32'(last_rd));
        end else begin
            check(rdata == model[a], {tag, " R5 read data"}, 32'(rdata), 32'(model[a]));
            last_rd = model[a];
        end
    endtask

    task automatic after_rdy(input string tag);
        @(negedge clk);
        check(rdy == 1'b0, {tag, " R3 single pulse"}, 32'(rdy), 0);
        check(rdata == last_rd, {tag, " R6 hold"}, 32'(rdata), 32'(last_rd));
    endtask

    task automatic t_reset;
        @(negedge clk);
        check(rdy == 1'b0 && proto_err == 1'b0, "R1 outputs", {rdy, proto_err}, 0);
        check(rdata == '0, "R1 rdata", 32'(rdata), 0);
        for (int i = 0; i < 8; i++) begin
            access(AW'(i), 1'b0, '0, "R1 readback");
            after_rdy("R1");
        end
    endtask

    task automatic t_write_read;
        for (int i = 0; i < 8; i++) begin
            access(AW'(i), 1'b1, DW'(16'h1111 * (i + 1)), "R2 write");
            after_rdy("R2");
        end
        for (int i = 7; i >= 0; i--) begin
            access(AW'(i), 1'b0, '0, "R2 read");
            after_rdy("R2");
        end
    endtask

    task automatic t_zero_wait;
        @(negedge clk);
        en = 1'b1; wr = 1'b0; addr = 3'd4;
        @(negedge clk);
        en = 1'b0;
        check(rdy == 1'b1, "R4 rdy next cycle", 32'(rdy), 1);
        check(rdata == model[4], "R4 data", 32'(rdata), 32'(model[4]));
        last_rd = model[4];
        after_rdy("R4");
    endtask

    task automatic t_scramble;
        access(3'd3, 1'b1, 16'hC0DE, "R7 write");
        after_rdy("R7");
        access(3'd3, 1'b0, '0, "R7 read");
        after_rdy("R7");
        access(3'd4, 1'b0, '0, "R7 other reg");
        after_rdy("R7");
    endtask

    task automatic t_overlap;
        logic [DW-1:0] old5 = model[5];
        @(negedge clk);
        en = 1'b1; wr = 1'b0; addr = 3'd3;
        @(negedge clk);
        wr = 1'b1; addr = 3'd5; wdata = 16'hBEEF;
        @(negedge clk);
        en = 1'b0; wr = 1'b0;
        check(proto_err == 1'b1, "R8 proto_err", 32'(proto_err), 1);
        check(rdy == 1'b0, "R8 no rdy", 32'(rdy), 0);
        @(negedge clk);
        check(proto_err == 1'b0 && rdy == 1'b0, "R8 quiet", {rdy, proto_err}, 0);
        @(negedge clk);
        check(rdy == 1'b1, "R8 original rdy", 32'(rdy), 1);
        check(rdata == model[3], "R8 original data", 32'(rdata), 32'(model[3]));
        last_rd = model[3];
        after_rdy("R8");
        @(negedge clk);
        check(rdy == 1'b0, "R8 no extra rdy", 32'(rdy), 0);
        access(3'd5, 1'b0, '0, "R8 dropped write");
        check(model[5] == old5, "R8 model", 32'(model[5]), 32'(old5));
        after_rdy("R8");
    endtask

    task automatic t_back_to_back;
        access(3'd0, 1'b1, 16'h5A5A, "R9 first");
        en = 1'b1; wr = 1'b0; addr = 3'd0;
        @(negedge clk);
        en = 1'b0;
        check(rdy == 1'b1, "R9 second rdy", 32'(rdy), 1);
        check(proto_err == 1'b0, "R9 no error", 32'(proto_err), 0);
        check(rdata == 16'h5A5A, "R9 data", 32'(rdata), 32'h5A5A);
        last_rd = 16'h5A5A;
        after_rdy("R9");
    endtask

    task automatic t_idle;
        for (int i = 0; i < 6; i++) begin
            @(negedge clk);
            check(rdy == 1'b0, "R10 idle rdy", 32'(rdy), 0);
        end
    endtask

    initial begin
        for (int i = 0; i < 8; i++) model[i] = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_write_read();
        t_zero_wait();
        t_scramble();
        t_overlap();
        t_back_to_back();
        t_idle();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule